// File: doc/BRIEF.md
# Staged Reset and Counter-Clear Distributor

This block conditions the chip-level resets for one clock domain. Two reset sources are merged into a single active-high reset request. The first is an active-low external pad that arrives asynchronously. The second is an active-high software reset from the configuration logic. The merged request passes through a chain of cascaded synchronizer stages. Each stage turns reset on at once, asynchronously, and turns it off only on a clock edge. Every stage output is brought out, so downstream blocks can hang off successive stages and leave reset one after another at a fixed spacing.

Every synchronizer is built three times. Each copy is a short flop chain, and a registered two-of-three majority vote merges the copies. A single upset flop therefore cannot reach the output.

A second path handles the request to zero the coarse time counters. The request can come from an external pin or from a software bit. It goes through the same kind of triplicated synchronizer and is then edge-detected. The block emits a one-cycle pulse for a consumer clocked in this fast domain. It also emits a two-cycle pulse for a consumer in a slower domain, which could otherwise miss a single fast cycle.

Top module: `rst_clear_dist`

## Requirements
- R1: When `ext_rst_n` goes low, every bit of `rst_out` goes high in the same time step, with no clock edge needed.
- R2: When `sw_rst` goes high (active-high), every bit of `rst_out` goes high in the same time step. Resets inside the block and at its outputs are active-high.
- R3: Once both reset sources are inactive, `rst_out[0]` goes low on the (SYNC_DEPTH+1)-th rising clock edge, counting the first edge after the release as edge 1.
- R4: Each stage k > 0 releases exactly SYNC_DEPTH+1 clock edges after stage k-1. A stage is never released while the stage before it is still in reset.
- R5: Each synchronizer holds three identical chains of SYNC_DEPTH flops. A registered two-of-three vote drives its output. When no flop is upset, the three copies agree at every clock edge.
- R6: A rising edge on the merged clear request (`ext_clr` OR `sw_clr`, both active-high) drives `clr_fast` high for exactly one cycle. The pulse starts at the first rising clock edge after the request.
- R7: `clr_slow` goes high at the same edge as `clr_fast` and stays high for exactly two cycles.
- R8: A clear request held high for any number of cycles yields exactly one pulse pair. A new pulse pair needs the request to stay low for at least SYNC_DEPTH+2 clock edges first.
- R9: Neither clear output is ever high while `rst_out[0]` is high. Releasing reset while a clear request is held produces no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast synchronous clock |
| ext_rst_n | input | 1 | External asynchronous reset, active-low |
| sw_rst | input | 1 | Software reset from configuration logic, active-high |
| ext_clr | input | 1 | External coarse-counter clear request, active-high |
| sw_clr | input | 1 | Software coarse-counter clear request, active-high |
| rst_out | output | N_STAGES | Active-high reset of each cascade stage, bit 0 released first |
| clr_fast | output | 1 | One-cycle counter-clear pulse for the fast-domain consumer |
| clr_slow | output | 1 | Two-cycle counter-clear pulse for the slow-domain consumer |

## Verification
The bench builds the block with N_STAGES = 4 and SYNC_DEPTH = 2. Four stages give three stage-to-stage gaps, so the release spacing is checked repeatedly. The last stage releases only on the twelfth edge, which lies well beyond any off-by-one in the chain. With a depth of 2, each stage step is three edges. A clear request must therefore stay low for four edges before it can fire again, and the random gap range straddles that threshold from the safe side. Directed cases cover software reset in mid-run, a clear request held through reset release, and long held requests.

// File: rtl/rcd_pkg.sv
package rcd_pkg;

  // Two-of-three majority of a triplicated bit.
  function automatic logic maj3(input logic [2:0] v);
    return (v[0] & v[1]) | (v[1] & v[2]) | (v[0] & v[2]);
  endfunction

  // Clock edges from the release of a synchronizer input to the release of
  // its voted output: the flop chain plus the voter register.
  function automatic int unsigned sync_latency(input int unsigned depth);
    return depth + 1;
  endfunction

  // Edge, counted from release of the merged source, at which stage k releases.
  function automatic int unsigned stage_release_edge(input int unsigned k,
                                                     input int unsigned depth);
    return (k + 1) * sync_latency(depth);
  endfunction

endpackage

// File: rtl/rcd_tmr_sync.sv
module rcd_tmr_sync #(
  parameter int unsigned DEPTH = 2
) (
  input  logic clk,
  input  logic async_set,
  output logic q,
  output logic agree
);
  import rcd_pkg::*;

  logic [2:0] taps;

  generate
    for (genvar g = 0; g < 3; g++) begin : g_copy
      logic [DEPTH-1:0] chain;
      always_ff @(posedge clk or posedge async_set) begin
        if (async_set) chain <= '1;
        else           chain <= {chain[DEPTH-2:0], 1'b0};
      end
      assign taps[g] = chain[DEPTH-1];
    end
  endgenerate

  always_ff @(posedge clk or posedge async_set) begin
    if (async_set) q <= 1'b1;
    else           q <= maj3(taps);
  end

  assign agree = (taps == 3'b000) || (taps == 3'b111);

endmodule

// File: rtl/rcd_clear_pulse.sv
module rcd_clear_pulse (
  input  logic clk,
  input  logic rst,
  input  logic lvl,
  output logic fast,
  output logic slow
);
  logic prev;
  logic rise;

  assign rise = lvl & ~prev;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) begin
      prev <= 1'b1;
      fast <= 1'b0;
      slow <= 1'b0;
    end else begin
      prev <= lvl;
      fast <= rise;
      slow <= rise | fast;
    end
  end

endmodule

// File: rtl/rst_clear_dist.sv
module rst_clear_dist #(
  parameter int unsigned N_STAGES   = 3,
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic                clk,
  input  logic                ext_rst_n,
  input  logic                sw_rst,
  input  logic                ext_clr,
  input  logic                sw_clr,
  output logic [N_STAGES-1:0] rst_out,
  output logic                clr_fast,
  output logic                clr_slow
);
  localparam int unsigned N_SYNC = N_STAGES + 1;

  logic              src_rst;
  logic              clr_req;
  logic              clr_src;
  logic              clr_sync;
  logic [N_SYNC-1:0] sync_agree;
  logic [N_STAGES:0] stage_in;

  assign src_rst     = ~ext_rst_n | sw_rst;
  assign clr_req     = ext_clr | sw_clr;
  assign clr_src     = clr_req | src_rst;
  assign stage_in[0] = src_rst;

  generate
    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
      rcd_tmr_sync #(.DEPTH(SYNC_DEPTH)) u_sync (
        .clk       (clk),
        .async_set (stage_in[k]),
        .q         (rst_out[k]),
        .agree     (sync_agree[k])
      );
      assign stage_in[k+1] = rst_out[k];
    end
  endgenerate

  rcd_tmr_sync #(.DEPTH(SYNC_DEPTH)) u_clr_sync (
    .clk       (clk),
    .async_set (clr_src),
    .q         (clr_sync),
    .agree     (sync_agree[N_STAGES])
  );

  rcd_clear_pulse u_pulse (
    .clk  (clk),
    .rst  (rst_out[0]),
    .lvl  (clr_sync),
    .fast (clr_fast),
    .slow (clr_slow)
  );

endmodule

// File: rtl/rst_clear_dist_chk.sv
module rst_clear_dist_chk #(
  parameter int unsigned N_STAGES = 3
) (
  input logic                clk,
  input logic                src_rst,
  input logic [N_STAGES-1:0] rst_out,
  input logic [N_STAGES:0]   sync_agree,
  input logic                clr_fast,
  input logic                clr_slow
);

  // R5: the three copies of every synchronizer agree
  p_copies_agree_r5: assert property (@(posedge clk) disable iff (src_rst)
    &sync_agree);

  // R6: the fast pulse lasts one cycle
  p_fast_single_r6: assert property (@(posedge clk) disable iff (rst_out[0])
    clr_fast |=> !clr_fast);

  // R7: the slow pulse covers the fast pulse and extends one cycle past it
  p_slow_covers_r7: assert property (@(posedge clk) disable iff (rst_out[0])
    clr_fast |-> clr_slow);
  p_slow_extends_r7: assert property (@(posedge clk) disable iff (rst_out[0])
    clr_fast |=> clr_slow);
  p_slow_ends_r7: assert property (@(posedge clk) disable iff (rst_out[0])
    (clr_slow && !clr_fast) |=> !clr_slow);

  // R9: no clear output while the first stage is in reset
  p_quiet_in_reset_r9: assert property (@(posedge clk)
    rst_out[0] |-> (!clr_fast && !clr_slow));

  // R4: stages release in order
  generate
    for (genvar k = 1; k < N_STAGES; k++) begin : g_order
      p_stage_order_r4: assert property (@(posedge clk) disable iff (src_rst)
        !rst_out[k] |-> !rst_out[k-1]);
    end
  endgenerate

endmodule

bind rst_clear_dist rst_clear_dist_chk #(.N_STAGES(N_STAGES)) u_chk (
  .clk        (clk),
  .src_rst    (src_rst),
  .rst_out    (rst_out),
  .sync_agree (sync_agree),
  .clr_fast   (clr_fast),
  .clr_slow   (clr_slow)
);

// File: tb/rst_clear_dist_bench.sv
module rst_clear_dist_bench;
  localparam int    NS     = 4;
  localparam int    DEPTH  = 2;
  localparam time   CLK_P  = 10;
  localparam int    STEP   = DEPTH + 1;

  logic          clk = 1'b0;
  logic          ext_rst_n, sw_rst, ext_clr, sw_clr;
  logic [NS-1:0] rst_out;
  logic          clr_fast, clr_slow;
  int            checks = 0;
  int            errors = 0;
  bit            done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  rst_clear_dist #(.N_STAGES(NS), .SYNC_DEPTH(DEPTH)) u_rst_clear_dist (
    .clk(clk), .ext_rst_n(ext_rst_n), .sw_rst(sw_rst), .ext_clr(ext_clr),
    .sw_clr(sw_clr), .rst_out(rst_out), .clr_fast(clr_fast), .clr_slow(clr_slow)
  );

  // Bench model: after the edge with index e (1-based) following release,
  // stage k has left reset once e reaches STEP times (k+1).
  function automatic logic [NS-1:0] exp_rst(input int e);
    logic [NS-1:0] v;
    for (int k = 0; k < NS; k++) v[k] = (e < STEP * (k + 1));
    return v;
  endfunction

  function automatic logic [1:0] exp_pulse(input int e); // {slow, fast}
    return {(e == 1 || e == 2), (e == 1)};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic edge_sample();
    @(posedge clk); #1;
  endtask

  task automatic release_and_check(input string tag);
    @(negedge clk);
    ext_rst_n = 1'b1; sw_rst = 1'b0;
    for (int e = 1; e <= STEP * NS + 2; e++) begin
      edge_sample();
      chk({tag, " R3 R4 stage release"}, 8'(rst_out), 8'(exp_rst(e)));
      chk({tag, " R9 no pulse on release"}, {6'd0, clr_slow, clr_fast}, 8'd0);
    end
  endtask

  task automatic clear_trial(input bit use_sw, input int hold, input int gap);
    @(negedge clk);
    if (use_sw) sw_clr = 1'b1; else ext_clr = 1'b1;
    for (int e = 1; e <= hold + gap; e++) begin
      edge_sample();
      chk("R6 R7 R8 clear pulses", {6'd0, clr_slow, clr_fast}, {6'd0, exp_pulse(e)});
      if (e == hold) begin
        @(negedge clk);
        sw_clr = 1'b0; ext_clr = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20130205));
    ext_rst_n = 1'b0; sw_rst = 1'b0; ext_clr = 1'b0; sw_clr = 1'b0;
    #1;
    chk("R1 async assert at start", 8'(rst_out), 8'((1 << NS) - 1));
    repeat (3) edge_sample();
    chk("R1 reset held", 8'(rst_out), 8'((1 << NS) - 1));
    chk("R9 quiet in reset", {6'd0, clr_slow, clr_fast}, 8'd0);
    release_and_check("ext");

    // Directed: a few clear pulses from each source
    clear_trial(1'b0, 1, 4);
    clear_trial(1'b1, 20, 5);

    // R2: software reset asserts without a clock edge
    @(negedge clk); #1;
    sw_rst = 1'b1; #1;
    chk("R2 sw reset async assert", 8'(rst_out), 8'((1 << NS) - 1));
    edge_sample();
    release_and_check("sw");

    // R1: external pad mid-run, asserted between edges
    @(negedge clk); #2;
    ext_rst_n = 1'b0; #1;
    chk("R1 pad async assert", 8'(rst_out), 8'((1 << NS) - 1));
    // R9: clear request raised during reset and held through release
    ext_clr = 1'b1;
    repeat (4) begin
      edge_sample();
      chk("R9 no pulse in reset", {6'd0, clr_slow, clr_fast}, 8'd0);
    end
    release_and_check("held-clear");
    @(negedge clk); ext_clr = 1'b0;
    repeat (STEP + 2) edge_sample();

    // Random clear requests; gaps of at least DEPTH+2 edges (R8)
    for (int t = 0; t < 40; t++) begin
      clear_trial(1'($urandom_range(1, 0)), int'($urandom_range(12, 1)),
                  int'($urandom_range(10, DEPTH + 2)));
    end

    // R5: voted output stays consistent after all traffic
    edge_sample();
    chk("R5 voted outputs settled", {4'd0, rst_out}, 8'd0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule